// File: doc/BRIEF.md
# Sub-word addressable general register file

This block holds eight 32-bit general registers and a separate 32-bit instruction pointer. Every register can be reached as a whole word or as its low 16-bit half. The first four registers can also be reached one byte at a time, either as bits 7:0 or as bits 15:8. Two independent combinational read ports and one synchronous write port each carry a 3-bit register code and a 2-bit access size. A narrow write merges its data into the addressed bits and leaves the rest of the register as it was. A narrow read returns the addressed field zero-extended to 32 bits.

The instruction pointer is a separate register. It can be loaded with a new address or stepped forward by a fixed amount. A load takes priority over a step. The block has no state machine. All state lives in the nine registers, and the behaviour comes from a shared code/size decoder. Each port has its own copy of that decoder.

Access size encoding: `00` byte, `01` half (bits 15:0), `10` word, `11` word. Register codes run 000 to 111 and select registers 0 to 7. The exception is byte size: there, codes 000 to 011 select bits 7:0 of registers 0 to 3, and codes 100 to 111 select bits 15:8 of registers 0 to 3.

Top module: `gpr_file`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all eight registers and the instruction pointer to zero.
- R2: With size `10` or `11`, a write replaces all 32 bits of the register selected by the code, and a read returns all 32 bits.
- R3: With size `01`, a write replaces only bits 15:0 of the selected register, and a read returns bits 15:0 in bits 15:0 of the port with bits 31:16 zero.
- R4: With size `00` and codes 000 to 011, a write replaces only bits 7:0 of registers 0 to 3, and a read returns those bits zero-extended.
- R5: With size `00` and codes 100 to 111, a write replaces only bits 15:8 of registers 0 to 3, a read returns those bits in bits 7:0 with bits 31:8 zero, and registers 4 to 7 are never changed by a byte write.
- R6: The two read ports are independent: each returns the value selected by its own code and size in the same cycle.
- R7: A read of the register being written in the same cycle returns the old value, and the new value appears in the following cycle.
- R8: With `wr_en` low, no register changes, whatever the other write inputs carry.
- R9: With `ip_load` high, the instruction pointer takes `ip_next` at the clock edge.
- R10: With `ip_inc` high and `ip_load` low, the instruction pointer increases by `IP_STEP` (default 1) at the clock edge, wrapping modulo 2^32.
- R11: When `ip_load` and `ip_inc` are both high, the load wins. When both are low, the instruction pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_code | input | 3 | Register code for the write |
| wr_size | input | 2 | Access size for the write |
| wr_data | input | 32 | Write data, aligned at bit 0 |
| ra_code | input | 3 | Register code, read port A |
| ra_size | input | 2 | Access size, read port A |
| ra_data | output | 32 | Read data, port A, zero-extended |
| rb_code | input | 3 | Register code, read port B |
| rb_size | input | 2 | Access size, read port B |
| rb_data | output | 32 | Read data, port B, zero-extended |
| ip_load | input | 1 | Load the instruction pointer from ip_next |
| ip_inc | input | 1 | Step the instruction pointer by IP_STEP |
| ip_next | input | 32 | New instruction pointer value |
| ip_value | output | 32 | Current instruction pointer |

## Verification
The hardest case is one register seen through several overlapping views. A high-byte write through codes 100 to 111 lands inside a half-word that a 16-bit write also covers, and the same register may be read in the very cycle it is written. The bench drives the write and the read for one register on the same falling edge. It samples the read port before the next rising edge to see the old value, and again after that edge to see the merged result. It also mixes byte, half and word writes on a single register and checks every view of it against a model built from the requirements.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    // Access size carried by every port
    typedef enum logic [1:0] {
        ACC_BYTE = 2'b00,
        ACC_HALF = 2'b01,
        ACC_WORD = 2'b10,
        ACC_WIDE = 2'b11
    } acc_size_e;

    localparam int unsigned BYTE_BITS = 8;
    localparam int unsigned HALF_BITS = 16;

endpackage

// File: rtl/gpr_lane_map.sv
module gpr_lane_map
    import gpr_pkg::*;
#(
    parameter int unsigned NREG = 8,
    parameter int unsigned XLEN = 32,
    localparam int unsigned IDXW = $clog2(NREG),
    localparam int unsigned SHW  = $clog2(XLEN)
) (
    input  logic [IDXW-1:0] code,
    input  logic [1:0]      size,
    output logic [IDXW-1:0] idx,
    output logic [XLEN-1:0] mask,
    output logic [SHW-1:0]  shift
);

    localparam logic [XLEN-1:0] BYTE_MASK = XLEN'({BYTE_BITS{1'b1}});
    localparam logic [XLEN-1:0] HALF_MASK = XLEN'({HALF_BITS{1'b1}});

    always_comb begin
        unique case (acc_size_e'(size))
            ACC_BYTE: begin
                // top code bit picks the upper byte of the half-word
                idx   = {1'b0, code[IDXW-2:0]};
                shift = code[IDXW-1] ? SHW'(BYTE_BITS) : '0;
                mask  = BYTE_MASK << shift;
            end
            ACC_HALF: begin
                idx   = code;
                shift = '0;
                mask  = HALF_MASK;
            end
            default: begin
                idx   = code;
                shift = '0;
                mask  = '1;
            end
        endcase
    end

endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
    parameter int unsigned NREG = 8,
    parameter int unsigned XLEN = 32,
    localparam int unsigned IDXW = $clog2(NREG),
    localparam int unsigned SHW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] regs [NREG],
    input  logic [IDXW-1:0] code,
    input  logic [1:0]      size,
    output logic [XLEN-1:0] data
);

    logic [IDXW-1:0] sel_idx;
    logic [XLEN-1:0] sel_mask;
    logic [SHW-1:0]  sel_shift;

    gpr_lane_map #(.NREG(NREG), .XLEN(XLEN)) u_map (
        .code  (code),
        .size  (size),
        .idx   (sel_idx),
        .mask  (sel_mask),
        .shift (sel_shift)
    );

    // Field extracted and moved down to bit 0, upper bits zero
    always_comb begin
        data = (regs[sel_idx] & sel_mask) >> sel_shift;
    end

endmodule

// File: rtl/gpr_ip_reg.sv
module gpr_ip_reg #(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned IP_STEP = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            inc,
    input  logic [XLEN-1:0] next,
    output logic [XLEN-1:0] value
);

    localparam logic [XLEN-1:0] STEP = XLEN'(IP_STEP);

    always_ff @(posedge clk) begin
        if (rst)       value <= '0;
        else if (load) value <= next;
        else if (inc)  value <= value + STEP;
    end

    // R9
    ip_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (value == $past(next)));

    // R10
    ip_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !load) |=> (value == $past(value) + STEP));

    // R11
    ip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!inc && !load) |=> $stable(value));

endmodule

// File: rtl/gpr_file.sv
module gpr_file
    import gpr_pkg::*;
#(
    parameter int unsigned NREG    = 8,
    parameter int unsigned XLEN    = 32,
    parameter int unsigned IP_STEP = 1,
    localparam int unsigned IDXW   = $clog2(NREG),
    localparam int unsigned SHW    = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_code,
    input  logic [1:0]      wr_size,
    input  logic [XLEN-1:0] wr_data,
    input  logic [IDXW-1:0] ra_code,
    input  logic [1:0]      ra_size,
    output logic [XLEN-1:0] ra_data,
    input  logic [IDXW-1:0] rb_code,
    input  logic [1:0]      rb_size,
    output logic [XLEN-1:0] rb_data,
    input  logic            ip_load,
    input  logic            ip_inc,
    input  logic [XLEN-1:0] ip_next,
    output logic [XLEN-1:0] ip_value
);

    logic [XLEN-1:0] regs [NREG];

    logic [IDXW-1:0] w_idx;
    logic [XLEN-1:0] w_mask;
    logic [SHW-1:0]  w_shift;
    logic [XLEN-1:0] w_field;

    gpr_lane_map #(.NREG(NREG), .XLEN(XLEN)) u_wmap (
        .code  (wr_code),
        .size  (wr_size),
        .idx   (w_idx),
        .mask  (w_mask),
        .shift (w_shift)
    );

    always_comb begin
        w_field = (wr_data << w_shift) & w_mask;
    end

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[gi] <= '0;
            end else if (wr_en && (w_idx == IDXW'(gi))) begin
                regs[gi] <= (regs[gi] & ~w_mask) | w_field;
            end
        end

        // R8
        idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !wr_en |=> $stable(regs[gi]));

        // R3
        merge_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (w_idx == IDXW'(gi)))
            |=> (((regs[gi] ^ $past(regs[gi])) & ~$past(w_mask)) == '0));

        if (gi >= NREG / 2) begin : g_upper
            // R5
            no_byte_upper_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_en && (wr_size == ACC_BYTE)) |=> $stable(regs[gi]));
        end
    end

    gpr_read_port #(.NREG(NREG), .XLEN(XLEN)) u_rda (
        .regs (regs),
        .code (ra_code),
        .size (ra_size),
        .data (ra_data)
    );

    gpr_read_port #(.NREG(NREG), .XLEN(XLEN)) u_rdb (
        .regs (regs),
        .code (rb_code),
        .size (rb_size),
        .data (rb_data)
    );

    gpr_ip_reg #(.XLEN(XLEN), .IP_STEP(IP_STEP)) u_ip (
        .clk   (clk),
        .rst   (rst),
        .load  (ip_load),
        .inc   (ip_inc),
        .next  (ip_next),
        .value (ip_value)
    );

    // R4
    byte_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (ra_size == ACC_BYTE) |-> (ra_data[XLEN-1:BYTE_BITS] == '0));

    // R3
    half_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (rb_size == ACC_HALF) |-> (rb_data[XLEN-1:HALF_BITS] == '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (ip_value == '0));

endmodule

// File: tb/sim_gpr_file.sv
module sim_gpr_file;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_code = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  ra_code = '0;
    logic [1:0]  ra_size = 2'b10;
    logic [31:0] ra_data;
    logic [2:0]  rb_code = '0;
    logic [1:0]  rb_size = 2'b10;
    logic [31:0] rb_data;
    logic        ip_load = 1'b0;
    logic        ip_inc = 1'b0;
    logic [31:0] ip_next = '0;
    logic [31:0] ip_value;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] mdl [8];
    logic [31:0] mdl_ip;

    always #4 clk = ~clk;

    gpr_file u0 (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_code(wr_code), .wr_size(wr_size), .wr_data(wr_data),
        .ra_code(ra_code), .ra_size(ra_size), .ra_data(ra_data),
        .rb_code(rb_code), .rb_size(rb_size), .rb_data(rb_data),
        .ip_load(ip_load), .ip_inc(ip_inc), .ip_next(ip_next), .ip_value(ip_value)
    );

    function automatic logic [31:0] m_read(input logic [2:0] c, input logic [1:0] s);
        if (s == 2'b00) return (mdl[c[1:0]] >> (c[2] ? 8 : 0)) & 32'hFF;
        if (s == 2'b01) return mdl[c] & 32'hFFFF;
        return mdl[c];
    endfunction

    task automatic m_write(input logic [2:0] c, input logic [1:0] s, input logic [31:0] d);
        if (s == 2'b00) begin
            if (c[2]) mdl[c[1:0]][15:8] = d[7:0];
            else      mdl[c[1:0]][7:0]  = d[7:0];
        end else if (s == 2'b01) begin
            mdl[c][15:0] = d[15:0];
        end else begin
            mdl[c] = d;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] c, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_code = c; wr_size = s; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        m_write(c, s, d);
    endtask

    task automatic read_a(input string req, input logic [2:0] c, input logic [1:0] s);
        @(negedge clk);
        ra_code = c; ra_size = s;
        #1;
        check(req, ra_data, m_read(c, s));
    endtask

    task automatic all_words(input string req);
        for (int i = 0; i < 8; i++) read_a(req, 3'(i), 2'b10);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) mdl[i] = '0;
        mdl_ip = '0;
    endtask

    task automatic t_reset;
        // R1: everything zero after reset
        all_words("R1");
        check("R1 ip", ip_value, 32'h0);
    endtask

    task automatic t_word;
        // R2: full words, both size codes
        for (int i = 0; i < 8; i++)
            do_write(3'(i), (i % 2 == 0) ? 2'b10 : 2'b11, 32'h1111_1111 * (i + 1) ^ 32'hA5A5_0F0F);
        all_words("R2");
        read_a("R2 wide", 3'd7, 2'b11);
        // R6: both ports at once with different views
        @(negedge clk);
        ra_code = 3'd2; ra_size = 2'b10;
        rb_code = 3'd5; rb_size = 2'b01;
        #1;
        check("R6 portA", ra_data, m_read(3'd2, 2'b10));
        check("R6 portB", rb_data, m_read(3'd5, 2'b01));
        rb_code = 3'd6; rb_size = 2'b00;
        #1;
        check("R6 portB byte", rb_data, m_read(3'd6, 2'b00));
    endtask

    task automatic t_half;
        // R3: half write keeps bits 31:16, half read zero-extends
        do_write(3'd5, 2'b01, 32'hFFFF_BEEF);
        read_a("R3 word", 3'd5, 2'b10);
        read_a("R3 half", 3'd5, 2'b01);
        check("R3 ext", ra_data, 32'h0000_BEEF);
    endtask

    task automatic t_byte_low;
        // R4: codes 0..3 with byte size touch bits 7:0
        do_write(3'd1, 2'b00, 32'hFFFF_FFA5);
        read_a("R4 word", 3'd1, 2'b10);
        read_a("R4 byte", 3'd1, 2'b00);
        check("R4 ext", ra_data, 32'h0000_00A5);
    endtask

    task automatic t_byte_high;
        logic [31:0] r6_before;
        r6_before = mdl[6];
        // R5: code 6 byte hits bits 15:8 of register 2
        do_write(3'd6, 2'b00, 32'h0000_003C);
        read_a("R5 word", 3'd2, 2'b10);
        read_a("R5 byte", 3'd6, 2'b00);
        check("R5 ext", ra_data, 32'h0000_003C);
        read_a("R5 reg6", 3'd6, 2'b10);
        check("R5 reg6 kept", ra_data, r6_before);
        // mixed views on register 0
        do_write(3'd0, 2'b10, 32'h1234_5678);
        do_write(3'd4, 2'b00, 32'h0000_00AB);
        do_write(3'd0, 2'b00, 32'h0000_00CD);
        read_a("R5 mixed", 3'd0, 2'b10);
        check("R5 mixed val", ra_data, 32'h1234_ABCD);
        read_a("R5 half", 3'd0, 2'b01);
    endtask

    task automatic t_rdw;
        logic [31:0] old_v;
        old_v = mdl[3];
        // R7: read during write sees the old value
        @(negedge clk);
        wr_en = 1'b1; wr_code = 3'd3; wr_size = 2'b10; wr_data = 32'hCAFE_F00D;
        ra_code = 3'd3; ra_size = 2'b10;
        #1;
        check("R7 old", ra_data, old_v);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        m_write(3'd3, 2'b10, 32'hCAFE_F00D);
        check("R7 new", ra_data, 32'hCAFE_F00D);
    endtask

    task automatic t_noen;
        // R8: inputs toggle with wr_en low
        @(negedge clk);
        wr_en = 1'b0; wr_code = 3'd4; wr_size = 2'b10; wr_data = 32'hDEAD_DEAD;
        @(negedge clk);
        wr_code = 3'd1; wr_size = 2'b00;
        @(negedge clk);
        all_words("R8");
    endtask

    task automatic t_ip;
        // R9: load
        @(negedge clk);
        ip_load = 1'b1; ip_next = 32'h0000_1000;
        @(negedge clk);
        ip_load = 1'b0;
        check("R9 load", ip_value, 32'h0000_1000);
        // R10: three steps
        ip_inc = 1'b1;
        repeat (3) @(negedge clk);
        ip_inc = 1'b0;
        check("R10 inc", ip_value, 32'h0000_1003);
        // R11: load beats step
        ip_load = 1'b1; ip_inc = 1'b1; ip_next = 32'hFFFF_FFFF;
        @(negedge clk);
        ip_load = 1'b0;
        check("R11 prio", ip_value, 32'hFFFF_FFFF);
        // R10: wrap
        @(negedge clk);
        ip_inc = 1'b0;
        check("R10 wrap", ip_value, 32'h0);
        // R11: hold
        repeat (2) @(negedge clk);
        check("R11 hold", ip_value, 32'h0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) mdl[i] = '0;
        mdl_ip = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_word();
        t_half();
        t_byte_low();
        t_byte_high();
        t_rdw();
        t_noen();
        t_ip();
        do_reset();
        t_reset();
        finish_run();
    end

endmodule